// File: doc/BRIEF.md
# Scratchpad-Mode Set-Associative Directory Controller

This block holds the tag directory of a set-associative last-level cache and decides, for each lookup, what the surrounding controller must do. It can run as an ordinary cache directory or as a fixed scratchpad. In scratchpad mode every line is resident from reset onward. Lines are never evicted. A lookup that misses is discarded without a refill and without a reply to the requester. A write to a widely shared line sends an invalidation broadcast, and the line stays resident, dirty and holding the new data.

After reset the block walks the directory one set per cycle. It fills every way as valid, with a tag built from the tile coordinates and the way index. Lookups arrive on a valid/ready request port that carries an opcode and a line address. Reads and cleanups that hit a counter-mode line in scratchpad mode first ask an external pending-invalidation table for access and then search it. Each lookup ends with a one-cycle response strobe that carries a decision code, side flags, and the directory entry that was written back. Data storage, refill and coherence message transport belong to neighbouring blocks.

Top module: `sdir_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low for 2 + SETS cycles: two reset synchroniser cycles, then a walk of one set per cycle. Every way w of every set then holds a valid entry with tag `({tile_x, tile_y} << (TAG_W - X_W - Y_W)) | w`, copy count 0, counter mode off, clean.
- R2: Scratchpad mode is on out of reset. A `cfg_wr_en` pulse sets the mode from `cfg_wr_data`: on if any bit is set, off if all bits are zero. `cfg_ack` is high for exactly the next cycle.
- R3: Opcodes are read = 0, write = 1, cleanup = 2. Response codes are hit = 0, drop = 1, retry = 2, broadcast = 3. A read hit returns hit and increments the copy count, saturating at its maximum. Counter mode turns on when the count before the read is at least COPY_LIMIT.
- R4: In scratchpad mode, a read or write miss returns drop, with `rsp_refill` = 0 and no directory update.
- R5: In normal mode, a read or write miss returns drop with `rsp_refill` = 1 and no update.
- R6: In scratchpad mode, a read hit on a counter-mode line raises `ivt_req` with the line on `ivt_line`. It gives no response while `ivt_gnt` is low. Once granted, a match returns retry with no update; no match returns hit with the copy update of R3. In normal mode no table access is made.
- R7: A write hit on a counter-mode line whose count is nonzero returns broadcast. In scratchpad mode the entry stays valid with its tag and counter-mode bit, becomes dirty, its count goes to 0, `rsp_wb` = 0, and later reads of the line still hit.
- R8: In normal mode the same write returns broadcast with `rsp_wb` = 1. The entry becomes invalid, so later lookups of the line miss.
- R9: Any other write hit returns hit. The entry becomes dirty and keeps its count and counter-mode bit.
- R10: In scratchpad mode, a cleanup hit on a counter-mode line waits for the table like R6. On a match it returns hit with no update. With no match it returns hit and updates the entry with the count decremented.
- R11: A cleanup hit decrements the count, which floors at 0. On a count of 0, `rsp_err` is 0 in scratchpad mode and 1 in normal mode. A cleanup miss returns drop.
- R12: Each accepted request yields exactly one response strobe, one cycle wide, on the second clock edge after acceptance or on the edge after the grant. `req_ready` is low while a lookup is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tile_x | input | X_W | Tile X coordinate used for preload tags |
| tile_y | input | Y_W | Tile Y coordinate used for preload tags |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wr_data | input | 32 | Mode register write data (nonzero enables scratchpad) |
| cfg_ack | output | 1 | Error-free acknowledge of a mode write |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_op | input | 2 | Opcode: 0 read, 1 write, 2 cleanup |
| req_line | input | TAG_W+log2(SETS) | Line address {tag, set} |
| ivt_req | output | 1 | Request for the pending-invalidation table |
| ivt_line | output | TAG_W+log2(SETS) | Line searched in the table |
| ivt_gnt | input | 1 | Table access granted this cycle |
| ivt_match | input | 1 | Search result, valid with the grant |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 0 hit, 1 drop, 2 retry, 3 broadcast |
| rsp_refill | output | 1 | Miss needs a refill (normal mode) |
| rsp_wb | output | 1 | Broadcast line must be written back (normal mode) |
| rsp_err | output | 1 | Cleanup on an entry with no copies (normal mode) |
| upd_en | output | 1 | Directory entry was rewritten |
| upd_set | output | log2(SETS) | Set of the rewritten entry |
| upd_way | output | log2(WAYS) | Way of the rewritten entry |
| upd_valid | output | 1 | New valid bit |
| upd_dirty | output | 1 | New dirty bit |
| upd_cnt_mode | output | 1 | New counter-mode bit |
| upd_count | output | CNT_W | New copy count |
| upd_tag | output | TAG_W | New tag |

## Verification
The assertions assume that `ivt_match` is meaningful only in a cycle where `ivt_gnt` is high. They also assume that `cfg_wr_en` does not fall in the middle of a pending lookup, because the mode is sampled at the resolving edge. The bench sets the grant and match levels while no lookup is pending, or while one is held waiting for a grant. It issues mode writes only between lookups and offers a new request only after the previous response has been seen.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CLEAN = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RC_HIT   = 2'd0,
    RC_DROP  = 2'd1,
    RC_RETRY = 2'd2,
    RC_BCAST = 2'd3
  } code_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } st_e;

endpackage

// File: rtl/sdir_walk.sv
module sdir_walk #(
  parameter int SETS = 4
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  output logic                    busy_o,
  output logic [$clog2(SETS)-1:0] set_o
);

  localparam int SET_W = $clog2(SETS);
  localparam logic [SET_W-1:0] LAST = SET_W'(SETS - 1);

  logic             busy_d;
  logic [SET_W-1:0] set_d;

  always_comb begin
    busy_d = busy_o;
    set_d  = set_o;
    if (busy_o) begin
      if (set_o == LAST) busy_d = 1'b0;
      else               set_d  = set_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b1;
      set_o  <= '0;
    end else if (busy_o) begin
      busy_o <= busy_d;
      set_o  <= set_d;
    end
  end

  // R1: the walk advances by exactly one set per cycle
  a_r1_walk_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && set_o != '0) |-> (set_o == $past(set_o) + 1'b1));

endmodule

// File: rtl/sdir_store.sv
module sdir_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_ni,
  input  logic                              fill_en,
  input  logic [$clog2(SETS)-1:0]           fill_set,
  input  logic [WAYS-1:0][TAG_W-1:0]        fill_tag,
  input  logic                              wr_en,
  input  logic [$clog2(SETS)-1:0]           wr_set,
  input  logic [$clog2(WAYS)-1:0]           wr_way,
  input  logic                              wr_valid,
  input  logic                              wr_dirty,
  input  logic                              wr_cnt,
  input  logic [CNT_W-1:0]                  wr_count,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic [$clog2(SETS)-1:0]           rd_set,
  output logic [WAYS-1:0]                   rd_valid,
  output logic [WAYS-1:0]                   rd_dirty,
  output logic [WAYS-1:0]                   rd_cnt,
  output logic [WAYS-1:0][CNT_W-1:0]        rd_count,
  output logic [WAYS-1:0][TAG_W-1:0]        rd_tag
);

  localparam int SET_W = $clog2(SETS);

  logic [SETS-1:0][WAYS-1:0]            v_q, v_d;
  logic [SETS-1:0][WAYS-1:0]            d_q, d_d;
  logic [SETS-1:0][WAYS-1:0]            c_q, c_d;
  logic [SETS-1:0][WAYS-1:0][CNT_W-1:0] n_q, n_d;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] t_q, t_d;

  always_comb begin
    v_d = v_q;
    d_d = d_q;
    c_d = c_q;
    n_d = n_q;
    t_d = t_q;
    for (int s = 0; s < SETS; s++) begin
      if (fill_en && fill_set == SET_W'(s)) begin
        for (int w = 0; w < WAYS; w++) begin
          v_d[s][w] = 1'b1;
          d_d[s][w] = 1'b0;
          c_d[s][w] = 1'b0;
          n_d[s][w] = '0;
          t_d[s][w] = fill_tag[w];
        end
      end
    end
    if (wr_en) begin
      v_d[wr_set][wr_way] = wr_valid;
      d_d[wr_set][wr_way] = wr_dirty;
      c_d[wr_set][wr_way] = wr_cnt;
      n_d[wr_set][wr_way] = wr_count;
      t_d[wr_set][wr_way] = wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      d_q <= '0;
      c_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (fill_en || wr_en) begin
      v_q <= v_d;
      d_q <= d_d;
      c_q <= c_d;
      n_q <= n_d;
      t_q <= t_d;
    end
  end

  assign rd_valid = v_q[rd_set];
  assign rd_dirty = d_q[rd_set];
  assign rd_cnt   = c_q[rd_set];
  assign rd_count = n_q[rd_set];
  assign rd_tag   = t_q[rd_set];

  // R1: the preload walk and lookup updates never collide
  a_r1_fill_excl: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_en |-> !wr_en);

endmodule

// File: rtl/sdir_decide.sv
module sdir_decide
  import sdir_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int TAG_W      = 8,
  parameter int CNT_W      = 3,
  parameter int COPY_LIMIT = 2
) (
  input  logic                       scratch,
  input  op_e                        op,
  input  logic [TAG_W-1:0]           tag,
  input  logic [WAYS-1:0]            rd_valid,
  input  logic [WAYS-1:0]            rd_dirty,
  input  logic [WAYS-1:0]            rd_cnt,
  input  logic [WAYS-1:0][CNT_W-1:0] rd_count,
  input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic                       ivt_gnt,
  input  logic                       ivt_match,
  output logic                       need_ivt,
  output logic                       resolve,
  output code_e                      code,
  output logic                       refill,
  output logic                       wb,
  output logic                       err,
  output logic                       upd_en,
  output logic [$clog2(WAYS)-1:0]    upd_way,
  output logic                       upd_valid,
  output logic                       upd_dirty,
  output logic                       upd_cnt,
  output logic [CNT_W-1:0]           upd_count,
  output logic [TAG_W-1:0]           upd_tag
);

  localparam int WAY_W = $clog2(WAYS);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(COPY_LIMIT);

  logic             hit;
  logic [WAY_W-1:0] hw;
  logic             e_dirty, e_cnt;
  logic [CNT_W-1:0] e_count;
  logic [TAG_W-1:0] e_tag;
  logic             pend;

  always_comb begin
    hit = 1'b0;
    hw  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && rd_valid[w] && rd_tag[w] == tag) begin
        hit = 1'b1;
        hw  = WAY_W'(w);
      end
    end
  end

  assign e_dirty  = rd_dirty[hw];
  assign e_cnt    = rd_cnt[hw];
  assign e_count  = rd_count[hw];
  assign e_tag    = rd_tag[hw];
  assign need_ivt = hit && scratch && e_cnt && (op == OP_READ || op == OP_CLEAN);
  assign resolve  = !need_ivt || ivt_gnt;
  assign pend     = need_ivt && ivt_match;
  assign upd_way  = hw;

  always_comb begin
    code      = RC_DROP;
    refill    = 1'b0;
    wb        = 1'b0;
    err       = 1'b0;
    upd_en    = 1'b0;
    upd_valid = 1'b1;
    upd_dirty = e_dirty;
    upd_cnt   = e_cnt;
    upd_count = e_count;
    upd_tag   = e_tag;
    unique case (op)
      OP_READ: begin
        if (!hit) begin
          refill = !scratch;
        end else if (pend) begin
          code = RC_RETRY;
        end else begin
          code      = RC_HIT;
          upd_en    = 1'b1;
          upd_count = (e_count == CNT_MAX) ? e_count : e_count + 1'b1;
          upd_cnt   = e_cnt || (e_count >= LIMIT);
        end
      end
      OP_WRITE: begin
        if (!hit) begin
          refill = !scratch;
        end else if (e_cnt && e_count != '0) begin
          code      = RC_BCAST;
          upd_en    = 1'b1;
          upd_count = '0;
          if (scratch) begin
            upd_dirty = 1'b1;
          end else begin
            wb        = 1'b1;
            upd_valid = 1'b0;
            upd_dirty = 1'b0;
            upd_cnt   = 1'b0;
            upd_tag   = '0;
          end
        end else begin
          code      = RC_HIT;
          upd_en    = 1'b1;
          upd_dirty = 1'b1;
        end
      end
      OP_CLEAN: begin
        if (hit) begin
          code = RC_HIT;
          if (!pend) begin
            upd_en    = 1'b1;
            upd_count = (e_count == '0) ? '0 : e_count - 1'b1;
            err       = !scratch && (e_count == '0);
          end
        end
      end
      default: code = RC_DROP;
    endcase
  end

endmodule

// File: rtl/sdir_ctrl.sv
module sdir_ctrl
  import sdir_pkg::*;
#(
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 8,
  parameter int X_W        = 2,
  parameter int Y_W        = 2,
  parameter int CNT_W      = 3,
  parameter int COPY_LIMIT = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [X_W-1:0]                   tile_x,
  input  logic [Y_W-1:0]                   tile_y,
  input  logic                             cfg_wr_en,
  input  logic [31:0]                      cfg_wr_data,
  output logic                             cfg_ack,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [1:0]                       req_op,
  input  logic [TAG_W+$clog2(SETS)-1:0]    req_line,
  output logic                             ivt_req,
  output logic [TAG_W+$clog2(SETS)-1:0]    ivt_line,
  input  logic                             ivt_gnt,
  input  logic                             ivt_match,
  output logic                             rsp_valid,
  output logic [1:0]                       rsp_code,
  output logic                             rsp_refill,
  output logic                             rsp_wb,
  output logic                             rsp_err,
  output logic                             upd_en,
  output logic [$clog2(SETS)-1:0]          upd_set,
  output logic [$clog2(WAYS)-1:0]          upd_way,
  output logic                             upd_valid,
  output logic                             upd_dirty,
  output logic                             upd_cnt_mode,
  output logic [CNT_W-1:0]                 upd_count,
  output logic [TAG_W-1:0]                 upd_tag
);

  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = TAG_W + SET_W;
  localparam int SHIFT  = TAG_W - X_W - Y_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i = sync_q[1];

  // preload walk
  logic             walk_busy;
  logic [SET_W-1:0] walk_set;
  logic [WAYS-1:0][TAG_W-1:0] fill_tag;

  sdir_walk #(.SETS(SETS)) u_walk (
    .clk    (clk),
    .rst_ni (rst_i),
    .busy_o (walk_busy),
    .set_o  (walk_set)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_fill
    assign fill_tag[w] = (TAG_W'({tile_x, tile_y}) << SHIFT) | TAG_W'(w);
  end

  // mode register
  logic mode_q, cfg_ack_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mode_q    <= 1'b1;
      cfg_ack_q <= 1'b0;
    end else begin
      cfg_ack_q <= cfg_wr_en;
      if (cfg_wr_en) mode_q <= |cfg_wr_data;
    end
  end
  assign cfg_ack = cfg_ack_q;

  // request capture and state
  st_e              state_q, state_d;
  op_e              op_q;
  logic [LINE_W-1:0] line_q;
  logic             accept, look;

  assign req_ready = !walk_busy && state_q == ST_IDLE;
  assign accept    = req_valid && req_ready;
  assign look      = state_q == ST_LOOK;

  // store and decision
  logic [WAYS-1:0]            rd_valid, rd_dirty, rd_cnt;
  logic [WAYS-1:0][CNT_W-1:0] rd_count;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic             need_ivt, resolve, d_refill, d_wb, d_err, d_upd;
  code_e            d_code;
  logic [WAY_W-1:0] d_way;
  logic             d_valid, d_dirty, d_cnt;
  logic [CNT_W-1:0] d_count;
  logic [TAG_W-1:0] d_tag;
  logic             finish;

  assign finish = look && resolve;

  sdir_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_ni   (rst_i),
    .fill_en  (walk_busy),
    .fill_set (walk_set),
    .fill_tag (fill_tag),
    .wr_en    (finish && d_upd),
    .wr_set   (line_q[SET_W-1:0]),
    .wr_way   (d_way),
    .wr_valid (d_valid),
    .wr_dirty (d_dirty),
    .wr_cnt   (d_cnt),
    .wr_count (d_count),
    .wr_tag   (d_tag),
    .rd_set   (line_q[SET_W-1:0]),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_cnt   (rd_cnt),
    .rd_count (rd_count),
    .rd_tag   (rd_tag)
  );

  sdir_decide #(.WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W), .COPY_LIMIT(COPY_LIMIT)) u_decide (
    .scratch   (mode_q),
    .op        (op_q),
    .tag       (line_q[LINE_W-1:SET_W]),
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_cnt    (rd_cnt),
    .rd_count  (rd_count),
    .rd_tag    (rd_tag),
    .ivt_gnt   (ivt_gnt),
    .ivt_match (ivt_match),
    .need_ivt  (need_ivt),
    .resolve   (resolve),
    .code      (d_code),
    .refill    (d_refill),
    .wb        (d_wb),
    .err       (d_err),
    .upd_en    (d_upd),
    .upd_way   (d_way),
    .upd_valid (d_valid),
    .upd_dirty (d_dirty),
    .upd_cnt   (d_cnt),
    .upd_count (d_count),
    .upd_tag   (d_tag)
  );

  assign ivt_req  = look && need_ivt;
  assign ivt_line = line_q;

  always_comb begin
    state_d = state_q;
    if (accept)      state_d = ST_LOOK;
    else if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= op_e'(req_op);
        line_q <= req_line;
      end
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rsp_valid    <= 1'b0;
      rsp_code     <= 2'd0;
      rsp_refill   <= 1'b0;
      rsp_wb       <= 1'b0;
      rsp_err      <= 1'b0;
      upd_en       <= 1'b0;
      upd_set      <= '0;
      upd_way      <= '0;
      upd_valid    <= 1'b0;
      upd_dirty    <= 1'b0;
      upd_cnt_mode <= 1'b0;
      upd_count    <= '0;
      upd_tag      <= '0;
    end else begin
      rsp_valid <= finish;
      upd_en    <= finish && d_upd;
      if (finish) begin
        rsp_code     <= d_code;
        rsp_refill   <= d_refill;
        rsp_wb       <= d_wb;
        rsp_err      <= d_err;
        upd_set      <= line_q[SET_W-1:0];
        upd_way      <= d_way;
        upd_valid    <= d_valid;
        upd_dirty    <= d_dirty;
        upd_cnt_mode <= d_cnt;
        upd_count    <= d_count;
        upd_tag      <= d_tag;
      end
    end
  end

  // R2: every mode write is acknowledged on the next cycle
  a_r2_cfg_ack: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_wr_en |=> cfg_ack);

  // R4: a drop never rewrites the directory
  a_r4_drop_no_update: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && rsp_code == RC_DROP) |-> !upd_en);

  // R4: scratchpad mode never asks for a refill
  a_r4_no_refill: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && $past(mode_q)) |-> !rsp_refill);

  // R6: no answer while the table is not granted
  a_r6_wait_grant: assert property (@(posedge clk) disable iff (!rst_i)
    (ivt_req && !ivt_gnt) |=> !rsp_valid);

  // R6: a retry only follows a granted search that matched
  a_r6_retry_match: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && rsp_code == RC_RETRY) |-> $past(ivt_req && ivt_gnt && ivt_match));

  // R7: scratchpad broadcast keeps the line resident and dirty
  a_r7_bcast_keep: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && rsp_code == RC_BCAST && $past(mode_q))
      |-> (upd_en && upd_valid && upd_dirty && upd_count == '0 && !rsp_wb));

  // R8: normal broadcast drops the line and writes it back
  a_r8_bcast_evict: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && rsp_code == RC_BCAST && !$past(mode_q)) |-> (rsp_wb && !upd_valid));

  // R12: a response only follows a pending lookup, and updates ride on it
  a_r12_rsp_origin: assert property (@(posedge clk) disable iff (!rst_i)
    rsp_valid |-> $past(state_q == ST_LOOK));
  a_r12_upd_with_rsp: assert property (@(posedge clk) disable iff (!rst_i)
    upd_en |-> rsp_valid);

endmodule

// File: tb/sdir_ctrl_bench.sv
`timescale 1ns/1ps
module sdir_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  tile_x, tile_y;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic        cfg_ack;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [9:0]  req_line;
  logic        ivt_req;
  logic [9:0]  ivt_line;
  logic        ivt_gnt, ivt_match;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic        rsp_refill, rsp_wb, rsp_err;
  logic        upd_en;
  logic [1:0]  upd_set, upd_way;
  logic        upd_valid, upd_dirty, upd_cnt_mode;
  logic [2:0]  upd_count;
  logic [7:0]  upd_tag;

  always #2 clk = ~clk;

  sdir_ctrl u_sdir_ctrl (
    .clk(clk), .rst_n(rst_n), .tile_x(tile_x), .tile_y(tile_y),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_ack(cfg_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_line(req_line),
    .ivt_req(ivt_req), .ivt_line(ivt_line), .ivt_gnt(ivt_gnt), .ivt_match(ivt_match),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_refill(rsp_refill),
    .rsp_wb(rsp_wb), .rsp_err(rsp_err), .upd_en(upd_en), .upd_set(upd_set),
    .upd_way(upd_way), .upd_valid(upd_valid), .upd_dirty(upd_dirty),
    .upd_cnt_mode(upd_cnt_mode), .upd_count(upd_count), .upd_tag(upd_tag)
  );

  localparam int OPR = 0, OPW = 1, OPC = 2;
  localparam int HIT = 0, DROP = 1, RETRY = 2, BCAST = 3;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  int c_code, c_refill, c_wb, c_err, c_upd, c_set, c_way;
  int c_v, c_d, c_cm, c_cnt, c_tag;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ptag(input int w);
    return ((1 * 4 + 2) << 4) | w;
  endfunction

  function automatic logic [9:0] mk(input int tag, input int s);
    return {8'(tag), 2'(s)};
  endfunction

  task automatic grab();
    c_code = rsp_code;   c_refill = rsp_refill; c_wb = rsp_wb; c_err = rsp_err;
    c_upd  = upd_en;     c_set = upd_set;       c_way = upd_way;
    c_v    = upd_valid;  c_d = upd_dirty;       c_cm = upd_cnt_mode;
    c_cnt  = upd_count;  c_tag = upd_tag;
  endtask

  task automatic do_req(input int op, input logic [9:0] line);
    int n;
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_op = 2'(op); req_line = line;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    if (!rsp_valid) begin
      chk("R12", "response missing", 0, 1);
      c_code = -1; c_upd = -1;
    end else begin
      grab();
      @(negedge clk);
      chk("R12", "strobe width", rsp_valid, 0);
    end
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk("R2", "cfg_ack", cfg_ack, 1);
    @(negedge clk);
    chk("R2", "cfg_ack one cycle", cfg_ack, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nerr++;
      $display("FAIL R12 watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; tile_x = 2'd1; tile_y = 2'd2;
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
    req_valid = 1'b0; req_op = '0; req_line = '0;
    ivt_gnt = 1'b1; ivt_match = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "reset rsp_valid", rsp_valid, 0);
    chk("R1", "reset ready", req_ready, 0);
    chk("R2", "reset cfg_ack", cfg_ack, 0);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req_ready) break;
      n++;
    end
    chk("R1", "busy cycles", n, 2 + 4 - 1);

    // R1/R3: every preloaded entry hits, first copy registered
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        do_req(OPR, mk(ptag(w), s));
        chk("R1", "preload hit", c_code, HIT);
        chk("R1", "preload way", c_way, w);
        chk("R1", "preload set", c_set, s);
        chk("R3", "first count", c_cnt, 1);
        chk("R1", "preload tag", c_tag, ptag(w));
      end
    end

    // R4: misses in scratchpad mode are dropped silently
    for (int s = 0; s < 4; s++) begin
      do_req(OPR, mk(8'h00, s));
      chk("R4", "read miss code", c_code, DROP);
      chk("R4", "read miss refill", c_refill, 0);
      chk("R4", "read miss update", c_upd, 0);
      do_req(OPW, mk(8'h10 + s, s));
      chk("R4", "write miss code", c_code, DROP);
      chk("R4", "write miss refill", c_refill, 0);
    end

    // R9: ordinary write hit
    do_req(OPW, mk(ptag(2), 3));
    chk("R9", "code", c_code, HIT);
    chk("R9", "dirty", c_d, 1);
    chk("R9", "count kept", c_cnt, 1);
    chk("R9", "wb", c_wb, 0);

    // R3: counter mode entry on the third copy
    do_req(OPR, mk(ptag(0), 0));
    chk("R3", "count 2", c_cnt, 2);
    chk("R3", "cnt off", c_cm, 0);
    do_req(OPR, mk(ptag(0), 0));
    chk("R3", "count 3", c_cnt, 3);
    chk("R3", "cnt on", c_cm, 1);

    // R6: read waits for the table grant, then retries on a match
    ivt_gnt = 1'b0; ivt_match = 1'b1;
    req_valid = 1'b1; req_op = 2'(OPR); req_line = mk(ptag(0), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6", "ivt_req", ivt_req, 1);
    chk("R6", "ivt_line", ivt_line, mk(ptag(0), 0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6", "no rsp without grant", rsp_valid, 0);
    end
    ivt_gnt = 1'b1;
    @(negedge clk);
    chk("R6", "rsp after grant", rsp_valid, 1);
    chk("R6", "retry code", rsp_code, RETRY);
    chk("R6", "retry update", upd_en, 0);
    @(negedge clk);
    do_req(OPR, mk(ptag(0), 0));
    chk("R6", "retry again", c_code, RETRY);
    ivt_match = 1'b0;
    do_req(OPR, mk(ptag(0), 0));
    chk("R6", "hit after clear", c_code, HIT);
    chk("R6", "count 4", c_cnt, 4);

    // R10: cleanup on a counter-mode line
    ivt_match = 1'b1;
    do_req(OPC, mk(ptag(0), 0));
    chk("R10", "match code", c_code, HIT);
    chk("R10", "match update", c_upd, 0);
    ivt_match = 1'b0;
    do_req(OPC, mk(ptag(0), 0));
    chk("R10", "nomatch update", c_upd, 1);
    chk("R10", "count 3", c_cnt, 3);

    // R7: scratchpad broadcast keeps the line
    do_req(OPW, mk(ptag(0), 0));
    chk("R7", "code", c_code, BCAST);
    chk("R7", "valid", c_v, 1);
    chk("R7", "dirty", c_d, 1);
    chk("R7", "cnt kept", c_cm, 1);
    chk("R7", "count", c_cnt, 0);
    chk("R7", "tag", c_tag, ptag(0));
    chk("R7", "wb", c_wb, 0);
    do_req(OPR, mk(ptag(0), 0));
    chk("R7", "still resident", c_code, HIT);
    chk("R7", "recount", c_cnt, 1);

    // R11: cleanup down to and below zero in scratchpad mode
    do_req(OPC, mk(ptag(1), 1));
    chk("R11", "count 0", c_cnt, 0);
    do_req(OPC, mk(ptag(1), 1));
    chk("R11", "scratch err", c_err, 0);
    chk("R11", "floor", c_cnt, 0);
    do_req(OPC, mk(8'h00, 1));
    chk("R11", "cleanup miss", c_code, DROP);

    // R2: switch to normal mode
    cfg_write(32'h0);
    do_req(OPR, mk(8'h00, 2));
    chk("R5", "read miss code", c_code, DROP);
    chk("R5", "read refill", c_refill, 1);
    do_req(OPW, mk(8'h00, 2));
    chk("R5", "write refill", c_refill, 1);
    chk("R2", "mode off", c_refill, 1);
    do_req(OPC, mk(ptag(1), 1));
    chk("R11", "normal err", c_err, 1);
    chk("R11", "normal code", c_code, HIT);

    // R8: normal broadcast evicts
    do_req(OPR, mk(ptag(0), 2));
    do_req(OPR, mk(ptag(0), 2));
    chk("R3", "cnt on normal", c_cm, 1);
    ivt_gnt = 1'b0;
    do_req(OPR, mk(ptag(0), 2));
    chk("R6", "no table in normal", c_code, HIT);
    chk("R6", "count 4 normal", c_cnt, 4);
    ivt_gnt = 1'b1;
    do_req(OPW, mk(ptag(0), 2));
    chk("R8", "code", c_code, BCAST);
    chk("R8", "wb", c_wb, 1);
    chk("R8", "valid", c_v, 0);
    do_req(OPR, mk(ptag(0), 2));
    chk("R8", "gone", c_code, DROP);
    chk("R8", "refill", c_refill, 1);

    // R2: nonzero write re-enables scratchpad
    cfg_write(32'h0000_0100);
    do_req(OPR, mk(ptag(0), 2));
    chk("R2", "scratch drop", c_code, DROP);
    chk("R2", "scratch no refill", c_refill, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule